// File: doc/BRIEF.md
# PWM Capture/Compare Channel

This block is one channel of a multi-channel timer. It has no counter of its own. It watches a count value that an outside timebase supplies, along with a period-start (overflow) strobe, an intermediate-overflow strobe and a count-direction flag. From these it shapes a single output pin. It can run as an edge-aligned PWM, a center-aligned PWM, a square-wave generator or an N-bit PWM. In timer/capture mode it instead records the count at the moment an external pin changes.

When the differential option is on, the channel also drives a complementary pair of phase outputs. A select bit decides which phase follows the channel output. Each compare event and each intermediate-overflow strobe can raise one-cycle interrupt, DMA-request and synchronization pulses, and every one of these has its own enable.

Configuration arrives through a narrow write port. The compare value can be loaded directly, or through a buffer that takes effect only at the next period start. A small two-state machine handles the buffered path:
- `UPD_IDLE`: no update is waiting. A buffered write takes it to `UPD_WAIT`.
- `UPD_WAIT`: an update is waiting. An overflow strobe with no new buffered write in the same cycle copies the buffer into the compare register and returns to `UPD_IDLE`. Another buffered write keeps it in `UPD_WAIT` and replaces the buffer contents.

The output path has no states of its own. Each cycle it computes the next level from the current mode and the events seen in that cycle.

Top module: `pwm_cc_channel`

## Requirements
- R1: While reset is asserted, all outputs are 0: the output level, both phase outputs, the pending flag, the compare value and all six pulse outputs. The configuration and enable registers also reset to 0.
- R2: Edge-aligned PWM (mode code 0). A compare match (`tb_count` equal to the compare value) applies the output action. An overflow strobe applies the inverse action, in which set and clear swap. If both happen in one cycle, the match wins. With action "set" and period P, the output is high for P−C cycles in every period, P cycles when C=0, and 0 cycles when C≥P.
- R3: Center-aligned PWM (mode code 1). A match while `tb_down`=0 applies the action, and a match while `tb_down`=1 applies the inverse action. With action "set", a count running up 0..P and then down P−1..1 keeps the output high for 2(P−C) cycles per period, for 0<C<P.
- R4: Square wave (mode code 2). Only a compare match applies the action, and the overflow strobe has no effect on the output. With action "toggle", the output changes exactly once per period and is high for half of every two periods.
- R5: N-bit PWM (mode code 4). Only the low N bits of the count and of the compare value are compared, where N is the resolution field. A match applies the action. The low N bits reaching zero without a match applies the inverse action. A field value of 0 acts as N=1, and values above the count width are clamped to the count width.
- R6: Output action codes: 0 toggles, 1 sets, 2 clears, 3 holds the level. The hold code never changes the output.
- R7: A write to select 3 loads the update buffer and raises `upd_pending`. The compare value stays as it was until the next overflow strobe. In the cycle of that strobe the buffer is copied in and the flag clears.
- R8: A write to select 2 loads the compare value on the next clock and leaves `upd_pending` unchanged.
- R9: Timer/capture mode (mode code 3). `cap_in` passes through two synchronizer flops. An enabled rising or falling edge then stores the current count as the compare value on the third clock edge after the pin changes. The same edge is a compare event: it applies the output action and can raise the compare pulses. An edge whose enable is clear has no effect.
- R10: A compare event raises `cmp_irq`, `cmp_dma` and `cmp_sync` for one cycle, on the clock after the event, each one only if its own enable is set.
- R11: A `tb_mid` strobe raises `mid_irq`, `mid_dma` and `mid_sync` for one cycle on the next clock, each one only if its own enable is set.
- R12: With the differential bit set, each output event drives the selected active phase to the new output level and the other phase to its complement. The active-phase bit chooses: 1 makes X active, 0 makes Y active. With the differential bit clear, `ph_x` and `ph_y` read 0.
- R13: Write-port layout, by select value:
  - Select 0: mode [2:0], action [4:3], resolution [8:5], differential enable [9], active phase [10].
  - Select 1: enables for rising capture [0], falling capture [1], compare irq/dma/sync [2]/[3]/[4], and intermediate irq/dma/sync [5]/[6]/[7].
  - Select 4: loads the output level [0], X phase [1] and Y phase [2] directly. This write takes priority over any event.
- R14: Mode codes 5 to 7 produce no output events and no compare pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_count | input | CNT_W | Shared timebase count |
| tb_ovf | input | 1 | Period-start (overflow) strobe |
| tb_mid | input | 1 | Intermediate-overflow strobe |
| tb_down | input | 1 | Count direction, 1 while counting down |
| cap_in | input | 1 | Asynchronous capture pin |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | CNT_W | Write data |
| ch_out | output | 1 | Channel output level |
| ph_x | output | 1 | X phase output |
| ph_y | output | 1 | Y phase output |
| upd_pending | output | 1 | Buffered compare update waiting |
| cmp_value | output | CNT_W | Active compare value |
| cmp_irq | output | 1 | Compare interrupt pulse |
| cmp_dma | output | 1 | Compare DMA-request pulse |
| cmp_sync | output | 1 | Compare synchronization pulse |
| mid_irq | output | 1 | Intermediate-overflow interrupt pulse |
| mid_dma | output | 1 | Intermediate-overflow DMA-request pulse |
| mid_sync | output | 1 | Intermediate-overflow synchronization pulse |

## Verification
The bench builds the channel with CNT_W=12 and SYNC_STAGES=2. The narrower word still holds every configuration field, and it keeps the bench's counts short. The bench drives periods of 16 counts for the edge, center and square modes and 64 counts for the N-bit mode. At these lengths it can sweep every compare value, including the match-on-overflow and never-match ends. It then checks each measured high time against the arithmetic formula for that mode. The two-flop synchronizer depth makes the capture latency a fixed three clocks, so the bench checks it at its exact cycle.

// File: rtl/pwm_cc_pkg.sv
package pwm_cc_pkg;

    typedef enum logic [2:0] {
        MODE_EDGE    = 3'd0,
        MODE_CENTER  = 3'd1,
        MODE_SQUARE  = 3'd2,
        MODE_CAPTURE = 3'd3,
        MODE_NBIT    = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        ACT_TOGGLE = 2'd0,
        ACT_SET    = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_HOLD   = 2'd3
    } act_e;

    typedef enum logic [2:0] {
        SEL_CFG   = 3'd0,
        SEL_EN    = 3'd1,
        SEL_CMP   = 3'd2,
        SEL_UPD   = 3'd3,
        SEL_STATE = 3'd4
    } sel_e;

    // Field order is the write-port layout (MSB first).
    typedef struct packed {
        logic       active_x;
        logic       diff_en;
        logic [3:0] nbits;
        act_e       act;
        logic [2:0] mode;
    } cfg_t;

    typedef struct packed {
        logic mid_sync;
        logic mid_dma;
        logic mid_irq;
        logic cmp_sync;
        logic cmp_dma;
        logic cmp_irq;
        logic cap_fall;
        logic cap_rise;
    } en_t;

    // Next output level for an action; inv swaps set and clear.
    function automatic logic drive_level(act_e a, logic cur, logic inv);
        logic r;
        unique case (a)
            ACT_TOGGLE: r = ~cur;
            ACT_SET:    r = ~inv;
            ACT_CLEAR:  r = inv;
            ACT_HOLD:   r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_cc_regs.sv
module pwm_cc_regs
    import pwm_cc_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tb_ovf,
    input  logic             cap_evt,
    input  logic [CNT_W-1:0] tb_count,
    output cfg_t             cfg,
    output en_t              en,
    output logic [CNT_W-1:0] cmp,
    output logic             pending,
    output logic             st_wr,
    output logic [2:0]       st_data
);

    localparam int CFG_W = $bits(cfg_t);
    localparam int EN_W  = $bits(en_t);

    typedef enum logic {UPD_IDLE, UPD_WAIT} upd_e;

    upd_e             upd_q, upd_d;
    logic [CNT_W-1:0] upd_buf;
    logic             wr_cfg, wr_en_reg, wr_cmp, wr_upd, xfer;

    assign wr_cfg    = wr_en && (wr_sel == SEL_CFG);
    assign wr_en_reg = wr_en && (wr_sel == SEL_EN);
    assign wr_cmp    = wr_en && (wr_sel == SEL_CMP);
    assign wr_upd    = wr_en && (wr_sel == SEL_UPD);
    assign st_wr     = wr_en && (wr_sel == SEL_STATE);
    assign st_data   = wr_data[2:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
            en  <= '0;
        end else begin
            if (wr_cfg)    cfg <= cfg_t'(wr_data[CFG_W-1:0]);
            if (wr_en_reg) en  <= en_t'(wr_data[EN_W-1:0]);
        end
    end

    // Update state register
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= UPD_IDLE;
        else        upd_q <= upd_d;
    end

    // Update transitions
    always_comb begin
        upd_d = upd_q;
        unique case (upd_q)
            UPD_IDLE: if (wr_upd)            upd_d = UPD_WAIT;
            UPD_WAIT: if (!wr_upd && tb_ovf) upd_d = UPD_IDLE;
        endcase
    end

    // Update outputs
    always_comb begin
        pending = (upd_q == UPD_WAIT);
        xfer    = (upd_q == UPD_WAIT) && tb_ovf && !wr_upd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_buf <= '0;
            cmp     <= '0;
        end else begin
            if (wr_upd) upd_buf <= wr_data;
            if (cap_evt)     cmp <= tb_count;
            else if (wr_cmp) cmp <= wr_data;
            else if (xfer)   cmp <= upd_buf;
        end
    end

    p_upd_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_upd |=> pending);

    p_upd_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && tb_ovf && !wr_upd && !wr_cmp && !cap_evt)
        |=> (!pending && cmp == $past(upd_buf)));

    p_direct_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmp && !cap_evt && !wr_upd && !tb_ovf)
        |=> (cmp == $past(wr_data) && pending == $past(pending)));

    p_cap_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cmp == $past(tb_count));

endmodule

// File: rtl/pwm_cc_capsync.sv
module pwm_cc_capsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/pwm_cc_engine.sv
module pwm_cc_engine
    import pwm_cc_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    input  en_t              en,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] tb_count,
    input  logic             tb_ovf,
    input  logic             tb_mid,
    input  logic             tb_down,
    input  logic             rise,
    input  logic             fall,
    input  logic             st_wr,
    input  logic [2:0]       st_data,
    output logic             cap_evt,
    output logic             out_q,
    output logic             x_q,
    output logic             y_q,
    output logic             cmp_irq,
    output logic             cmp_dma,
    output logic             cmp_sync,
    output logic             mid_irq,
    output logic             mid_dma,
    output logic             mid_sync
);

    localparam logic [4:0] W5 = 5'(CNT_W);

    logic [4:0]       n_eff;
    logic [CNT_W-1:0] mask;
    logic             full_match, low_match, low_wrap;
    logic             ev_fwd, ev_rev, ev_cmp, nxt;

    always_comb begin
        if (cfg.nbits == 4'd0)            n_eff = 5'd1;
        else if (int'(cfg.nbits) > CNT_W) n_eff = W5;
        else                              n_eff = {1'b0, cfg.nbits};
        mask       = {CNT_W{1'b1}} >> (W5 - n_eff);
        full_match = (tb_count == cmp);
        low_match  = ((tb_count & mask) == (cmp & mask));
        low_wrap   = ((tb_count & mask) == '0);
    end

    assign cap_evt = (cfg.mode == MODE_CAPTURE) &&
                     ((rise && en.cap_rise) || (fall && en.cap_fall));

    // Event decode per mode
    always_comb begin
        ev_fwd = 1'b0;
        ev_rev = 1'b0;
        ev_cmp = 1'b0;
        case (cfg.mode)
            MODE_EDGE: begin
                ev_fwd = full_match;
                ev_rev = tb_ovf && !full_match;
                ev_cmp = full_match;
            end
            MODE_CENTER: begin
                ev_fwd = full_match && !tb_down;
                ev_rev = full_match && tb_down;
                ev_cmp = full_match;
            end
            MODE_SQUARE: begin
                ev_fwd = full_match;
                ev_cmp = full_match;
            end
            MODE_CAPTURE: begin
                ev_fwd = cap_evt;
                ev_cmp = cap_evt;
            end
            MODE_NBIT: begin
                ev_fwd = low_match;
                ev_rev = low_wrap && !low_match;
                ev_cmp = low_match;
            end
            default: ;
        endcase
        if (ev_fwd)      nxt = drive_level(cfg.act, out_q, 1'b0);
        else if (ev_rev) nxt = drive_level(cfg.act, out_q, 1'b1);
        else             nxt = out_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            x_q   <= 1'b0;
            y_q   <= 1'b0;
        end else if (st_wr) begin
            out_q <= st_data[0];
            x_q   <= st_data[1];
            y_q   <= st_data[2];
        end else begin
            out_q <= nxt;
            if (cfg.diff_en && (ev_fwd || ev_rev)) begin
                x_q <= cfg.active_x ? nxt : ~nxt;
                y_q <= cfg.active_x ? ~nxt : nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cmp_irq, cmp_dma, cmp_sync} <= '0;
            {mid_irq, mid_dma, mid_sync} <= '0;
        end else begin
            cmp_irq  <= ev_cmp && en.cmp_irq;
            cmp_dma  <= ev_cmp && en.cmp_dma;
            cmp_sync <= ev_cmp && en.cmp_sync;
            mid_irq  <= tb_mid && en.mid_irq;
            mid_dma  <= tb_mid && en.mid_dma;
            mid_sync <= tb_mid && en.mid_sync;
        end
    end

    p_edge_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == MODE_EDGE && cfg.act == ACT_SET && tb_ovf &&
         tb_count == cmp && !st_wr) |=> out_q);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.act == ACT_HOLD && !st_wr) |=> $stable(out_q));

    p_mid_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en.mid_irq |=> !mid_irq);

    p_diff_x_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.diff_en && cfg.active_x && (ev_fwd || ev_rev) && !st_wr)
        |=> (x_q == out_q && y_q != out_q));

    p_state_wr_r13: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> (out_q == $past(st_data[0]) && x_q == $past(st_data[1]) &&
                   y_q == $past(st_data[2])));

    p_reserved_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode > 3'd4 && !st_wr)
        |=> ($stable(out_q) && !cmp_irq && !cmp_dma && !cmp_sync));

endmodule

// File: rtl/pwm_cc_channel.sv
module pwm_cc_channel
    import pwm_cc_pkg::*;
#(
    parameter int CNT_W       = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tb_count,
    input  logic             tb_ovf,
    input  logic             tb_mid,
    input  logic             tb_down,
    input  logic             cap_in,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             ch_out,
    output logic             ph_x,
    output logic             ph_y,
    output logic             upd_pending,
    output logic [CNT_W-1:0] cmp_value,
    output logic             cmp_irq,
    output logic             cmp_dma,
    output logic             cmp_sync,
    output logic             mid_irq,
    output logic             mid_dma,
    output logic             mid_sync
);

    cfg_t       cfg;
    en_t        en;
    logic       cap_evt, st_wr, rise, fall, out_q, x_q, y_q;
    logic [2:0] st_data;

    pwm_cc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tb_ovf(tb_ovf), .cap_evt(cap_evt),
        .tb_count(tb_count), .cfg(cfg), .en(en), .cmp(cmp_value),
        .pending(upd_pending), .st_wr(st_wr), .st_data(st_data)
    );

    pwm_cc_capsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(cap_in), .rise(rise), .fall(fall)
    );

    pwm_cc_engine #(.CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .en(en), .cmp(cmp_value),
        .tb_count(tb_count), .tb_ovf(tb_ovf), .tb_mid(tb_mid),
        .tb_down(tb_down), .rise(rise), .fall(fall), .st_wr(st_wr),
        .st_data(st_data), .cap_evt(cap_evt), .out_q(out_q), .x_q(x_q),
        .y_q(y_q), .cmp_irq(cmp_irq), .cmp_dma(cmp_dma),
        .cmp_sync(cmp_sync), .mid_irq(mid_irq), .mid_dma(mid_dma),
        .mid_sync(mid_sync)
    );

    assign ch_out = out_q;
    assign ph_x   = cfg.diff_en & x_q;
    assign ph_y   = cfg.diff_en & y_q;

endmodule

// File: tb/test_pwm_cc_channel.sv
`timescale 1ns/1ps
module test_pwm_cc_channel;

    localparam int W = 12;

    logic         clk = 1'b0, rst_n = 1'b0;
    logic [W-1:0] tb_count = '0, wr_data = '0;
    logic         tb_ovf = 0, tb_mid = 0, tb_down = 0, cap_in = 0, wr_en = 0;
    logic [2:0]   wr_sel = '0;
    logic         ch_out, ph_x, ph_y, upd_pending;
    logic [W-1:0] cmp_value;
    logic         cmp_irq, cmp_dma, cmp_sync, mid_irq, mid_dma, mid_sync;

    int n_chk = 0, n_err = 0;
    int hi, tr, irqs, dmas, syncs, mis_x, mis_y;
    logic prev_out;

    pwm_cc_channel #(.CNT_W(W), .SYNC_STAGES(2)) i_pwm_cc_channel (
        .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .tb_ovf(tb_ovf),
        .tb_mid(tb_mid), .tb_down(tb_down), .cap_in(cap_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .ch_out(ch_out), .ph_x(ph_x),
        .ph_y(ph_y), .upd_pending(upd_pending), .cmp_value(cmp_value),
        .cmp_irq(cmp_irq), .cmp_dma(cmp_dma), .cmp_sync(cmp_sync),
        .mid_irq(mid_irq), .mid_dma(mid_dma), .mid_sync(mid_sync)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] cfgw(input int mode, input int act,
                                          input int nb, input int diff, input int ax);
        return W'(mode | (act << 3) | (nb << 5) | (diff << 9) | (ax << 10));
    endfunction

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1; wr_sel = 3'(sel); wr_data = W'(data);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic clr();
        hi = 0; tr = 0; irqs = 0; dmas = 0; syncs = 0; mis_x = 0; mis_y = 0;
    endtask

    task automatic sample();
        hi    += int'(ch_out);
        tr    += int'(ch_out != prev_out);
        prev_out = ch_out;
        irqs  += int'(cmp_irq);
        dmas  += int'(cmp_dma);
        syncs += int'(cmp_sync);
        mis_x += int'(!(ph_x == ch_out && ph_y == !ch_out));
        mis_y += int'(!(ph_y == ch_out && ph_x == !ch_out));
    endtask

    // kind 0: count 0..P-1; kind 1: up 0..P then down P-1..1
    task automatic run(input int kind, input int P, input int warm, input int meas);
        for (int r = 0; r < warm + meas; r++) begin
            int len;
            len = (kind == 1) ? 2 * P : P;
            for (int i = 0; i < len; i++) begin
                @(negedge clk);
                if (r == warm && i == 0) prev_out = ch_out;
                if (r >= warm) sample();
                if (kind == 1 && i > P) begin
                    tb_count = W'(2 * P - i); tb_down = 1;
                end else begin
                    tb_count = W'(i); tb_down = 0;
                end
                tb_ovf = (i == 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic o_before;
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 out", int'(ch_out), 0);
        check("R1 phases", int'({ph_x, ph_y}), 0);
        check("R1 pending", int'(upd_pending), 0);
        check("R1 cmp", int'(cmp_value), 0);
        check("R1 pulses", int'({cmp_irq, cmp_dma, cmp_sync, mid_irq, mid_dma, mid_sync}), 0);
        rst_n = 1;
        tb_count = W'(15);

        // R2 edge PWM, action set, full compare sweep
        wr(0, cfgw(0, 1, 0, 0, 0));
        for (int c = 0; c <= 17; c++) begin
            wr(2, c); clr(); run(0, 16, 1, 1);
            check($sformatf("R2 edge set C=%0d", c), hi, (c == 0) ? 16 : (c < 16 ? 16 - c : 0));
        end

        // R6 edge PWM, action clear
        wr(0, cfgw(0, 2, 0, 0, 0));
        for (int c = 0; c <= 16; c += 4) begin
            wr(2, c); clr(); run(0, 16, 1, 1);
            check($sformatf("R6 edge clear C=%0d", c), hi, (c == 0) ? 0 : (c < 16 ? c : 16));
        end

        // R6 hold, R13 direct state write, R12 phases off
        wr(0, cfgw(0, 3, 0, 0, 0));
        wr(4, 1); clr(); run(0, 16, 0, 2);
        check("R6 hold keeps level", hi, 32);
        check("R12 phases low when off", int'({ph_x, ph_y}), 0);

        // R3 center-aligned sweep
        wr(0, cfgw(1, 1, 0, 0, 0));
        for (int c = 1; c <= 15; c++) begin
            wr(2, c); clr(); run(1, 16, 1, 1);
            check($sformatf("R3 center C=%0d", c), hi, 2 * (16 - c));
        end

        // R4 square wave
        wr(0, cfgw(2, 0, 0, 0, 0));
        wr(2, 5); clr(); run(0, 16, 1, 2);
        check("R4 square high", hi, 16);
        check("R4 square toggles", tr, 2);

        // R5 n-bit PWM, N=3, upper compare bits ignored
        wr(0, cfgw(4, 1, 3, 0, 0));
        for (int c = 0; c <= 7; c++) begin
            wr(2, c | 'h28); clr(); run(0, 64, 1, 1);
            check($sformatf("R5 nbit C=%0d", c), hi, (c == 0) ? 64 : 8 * (8 - c));
        end
        wr(0, cfgw(4, 1, 0, 0, 0));
        wr(2, 1); clr(); run(0, 64, 1, 1);
        check("R5 nbit field 0 as N=1", hi, 32);

        // R14 reserved mode
        wr(0, cfgw(5, 0, 0, 0, 0));
        wr(1, 'h1C); wr(2, 4); wr(4, 1); clr(); run(0, 16, 0, 1);
        check("R14 reserved level", hi, 16);
        check("R14 reserved pulses", irqs + dmas + syncs, 0);

        // R10 compare pulses gated
        wr(0, cfgw(0, 1, 0, 0, 0));
        wr(1, 'h14); wr(2, 4); clr(); run(0, 16, 1, 1);
        check("R10 irq count", irqs, 1);
        check("R10 dma gated", dmas, 0);
        check("R10 sync count", syncs, 1);
        @(negedge clk); tb_count = W'(4); tb_ovf = 0;
        @(negedge clk); check("R10 irq next cycle", int'(cmp_irq), 1);
        tb_count = W'(5);
        @(negedge clk); check("R10 irq one cycle", int'(cmp_irq), 0);

        // R11 intermediate pulses
        wr(1, 'h40);
        @(negedge clk); tb_mid = 1;
        @(negedge clk); tb_mid = 0;
        check("R11 mid dma", int'(mid_dma), 1);
        check("R11 mid irq/sync gated", int'({mid_irq, mid_sync}), 0);
        @(negedge clk); check("R11 mid one cycle", int'(mid_dma), 0);

        // R7 buffered update, R8 direct write
        tb_count = W'(100);
        wr(3, 7);
        check("R7 pending set", int'(upd_pending), 1);
        check("R7 cmp held", int'(cmp_value), 4);
        repeat (5) @(negedge clk);
        check("R7 waits for overflow", int'(upd_pending), 1);
        tb_ovf = 1; @(negedge clk); tb_ovf = 0;
        check("R7 pending cleared", int'(upd_pending), 0);
        check("R7 cmp applied", int'(cmp_value), 7);
        wr(3, 9); wr(2, 3);
        check("R8 direct cmp", int'(cmp_value), 3);
        check("R8 pending kept", int'(upd_pending), 1);
        tb_ovf = 1; @(negedge clk); tb_ovf = 0;
        check("R7 later apply", int'(cmp_value), 9);

        // R9 capture
        wr(0, cfgw(3, 0, 0, 0, 0));
        wr(1, 'h05);
        tb_count = W'('h123);
        o_before = ch_out;
        cap_in = 1;
        @(negedge clk); @(negedge clk);
        check("R9 not yet captured", int'(cmp_value), 9);
        @(negedge clk);
        check("R9 captured on third edge", int'(cmp_value), 'h123);
        check("R9 capture irq", int'(cmp_irq), 1);
        check("R9 capture applies toggle", int'(ch_out), int'(!o_before));
        tb_count = W'('hAB); cap_in = 0; clr();
        repeat (5) begin @(negedge clk); irqs += int'(cmp_irq); end
        check("R9 falling disabled ignored", int'(cmp_value), 'h123);
        check("R9 no event when disabled", irqs, 0);
        wr(1, 'h06);
        cap_in = 1; repeat (5) @(negedge clk);
        check("R9 rising disabled ignored", int'(cmp_value), 'h123);
        tb_count = W'('hCD); cap_in = 0; clr();
        repeat (5) begin @(negedge clk); irqs += int'(cmp_irq); end
        check("R9 falling capture", int'(cmp_value), 'hCD);
        check("R9 falling event", irqs, 1);

        // R12 differential
        wr(1, 0);
        wr(0, cfgw(0, 1, 0, 1, 1));
        wr(2, 6); clr(); run(0, 16, 1, 1);
        check("R12 X active", mis_x, 0);
        check("R12 high time", hi, 10);
        wr(0, cfgw(0, 1, 0, 1, 0));
        clr(); run(0, 16, 1, 1);
        check("R12 Y active", mis_y, 0);
        wr(0, cfgw(0, 3, 0, 1, 1));
        wr(4, 6);
        check("R13 state write level", int'(ch_out), 0);
        check("R13 state write phases", int'({ph_x, ph_y}), 3);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule